// File: doc/BRIEF.md
# Addressed Serial Register Control Port

This block is a serial slave that lets a host controller read and write a small internal register file over a four-wire link. The four wires are an active-low select, a bit clock, a data input and a data output that can float. The block runs directly on the serial bit clock. The select line is an asynchronous reset for all per-frame state, so every select-low period is one self-contained frame.

Every frame opens with a header byte. The top seven bits are a fixed device identity and the last bit is the transfer direction.

- **Write frame.** The header is followed by a pointer byte. Bit 7 of the pointer byte is an auto-step flag and the low bits select a register. Every complete byte after the pointer byte is stored at the pointed register.
- **Read frame.** The block returns register contents, starting at the pointer left by an earlier write frame. That earlier frame may end right after its pointer byte.
- **Auto-step.** When the flag is set, the pointer moves forward after each transferred byte and wraps at the end of the array.

A parallel read port and a write strobe let the surrounding logic, or a bench, see the register contents and each store as it happens.

Top module: `spi_reg_port`

## Requirements
- R1: After `rst_n` is released, every register reads 0 and the pointer index and auto-step flag are 0. `sdo_oe` is 0 while `csn` is high.
- R2: If header bits 7:1 differ from binary 1001111, the rest of the frame is ignored. No register changes, `wr_stb` stays 0, `sdo_oe` stays 0, and the pointer and flag keep their values.
- R3: Input bits are sampled on rising `sck` edges, MSB first. `sdo` changes only on falling `sck` edges and holds its value across the rising edge that follows.
- R4: In a write frame (header 0x9E), each complete data byte after the pointer byte is stored at the pointed register. `wr_stb` is high while the eighth bit of that byte is on `sdi`. During that time `wr_idx` shows the pointer index and `wr_byte` shows the byte being completed.
- R5: With the auto-step flag at 0, the pointer stays put. Successive written bytes all land in the same register, and successive read bytes all return that register.
- R6: With the auto-step flag at 1, the pointer advances by one after each byte written or read, and wraps modulo REG_COUNT.
- R7: When `csn` rises after a complete pointer byte, the new pointer and flag are kept. A data byte cut short by `csn` is discarded, and so is a pointer byte cut short by `csn`.
- R8: In a read frame (header 0x9F), `sdo_oe` is still 0 at the rising edge of the eighth header bit. On the next falling edge it goes to 1 and `sdo` shows the MSB of the pointed register. `sdo_oe` is 0 throughout every write frame.
- R9: Pointer byte bit 7 is the auto-step flag. The register index is bits 6:0 taken modulo REG_COUNT, where REG_COUNT is a power of two.
- R10: `rd_data` always equals the register selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset of registers and pointer |
| csn | input | 1 | Active-low frame select; high clears frame state |
| sck | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data from host, MSB first |
| sdo | output | 1 | Serial data to host, high impedance when not driving |
| sdo_oe | output | 1 | High while `sdo` is driven |
| rd_addr | input | $clog2(REG_COUNT) | Parallel read port index |
| rd_data | output | 8 | Contents of the register at `rd_addr` |
| wr_stb | output | 1 | High during the final bit of a data byte that will be stored |
| wr_idx | output | $clog2(REG_COUNT) | Register index being written |
| wr_byte | output | 8 | Byte being written |

## Verification
The hardest situations to reach are frames that are cut short. One is a pointer byte cut off partway, which must leave the old pointer in force. The other is a data byte cut off after five bits, which must not store anything while still keeping the pointer set just before it. The bench builds these frames bit by bit with its own serial driver and then proves the pointer state by running a read frame. The same driver sweeps all 127 wrong device identities, with both write and read direction bits. Auto-step runs cross the end of the array in both the write and the read direction.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam logic [6:0] DEV_ID = 7'b1001111;

  typedef enum logic [2:0] {
    FR_DEV  = 3'd0,
    FR_PTR  = 3'd1,
    FR_DATA = 3'd2,
    FR_READ = 3'd3,
    FR_SKIP = 3'd4
  } frame_st_t;

  function automatic logic dev_hit(input logic [7:0] hdr);
    return hdr[7:1] == DEV_ID;
  endfunction

  function automatic logic hdr_is_read(input logic [7:0] hdr);
    return hdr[0];
  endfunction

  function automatic frame_st_t after_header(input logic [7:0] hdr);
    if (!dev_hit(hdr)) return FR_SKIP;
    return hdr_is_read(hdr) ? FR_READ : FR_PTR;
  endfunction

endpackage

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
  import spi_ctl_pkg::*;
(
  input  logic      rst_n,
  input  logic      csn,
  input  logic      sck,
  input  logic      sdi,
  output frame_st_t state,
  output logic [2:0] bit_cnt,
  output logic [7:0] rx_byte,
  output logic      ev_ptr_load,
  output logic      ev_data_wr,
  output logic      ev_rd_step,
  output logic      read_active
);

  logic [6:0] sh;
  logic       byte_end;

  assign rx_byte  = {sh, sdi};
  assign byte_end = (bit_cnt == 3'd7) && !csn;

  always_ff @(posedge sck or posedge csn or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_DEV;
      bit_cnt <= 3'd0;
      sh      <= 7'd0;
    end else if (csn) begin
      state   <= FR_DEV;
      bit_cnt <= 3'd0;
      sh      <= 7'd0;
    end else begin
      bit_cnt <= bit_cnt + 3'd1;
      sh      <= {sh[5:0], sdi};
      if (byte_end) begin
        case (state)
          FR_DEV:  state <= after_header(rx_byte);
          FR_PTR:  state <= FR_DATA;
          default: state <= state;
        endcase
      end
    end
  end

  assign ev_ptr_load = byte_end && (state == FR_PTR);
  assign ev_data_wr  = byte_end && (state == FR_DATA);
  assign ev_rd_step  = byte_end && (state == FR_READ);
  assign read_active = (state == FR_READ);

  AST_DEV_GATE: assert property (@(posedge sck) disable iff (!rst_n || csn)
    (state == FR_DEV && byte_end && rx_byte[7:1] != 7'b1001111) |=> (state == FR_SKIP)); // R2

  AST_SKIP_STICKY: assert property (@(posedge sck) disable iff (!rst_n || csn)
    (state == FR_SKIP) |=> (state == FR_SKIP && !ev_data_wr && !read_active)); // R2

endmodule

// File: rtl/spi_ptr_unit.sv
module spi_ptr_unit #(
  parameter int IDX_W = 4
) (
  input  logic             rst_n,
  input  logic             sck,
  input  logic             ev_ptr_load,
  input  logic             ev_step,
  input  logic             new_inc,
  input  logic [IDX_W-1:0] new_idx,
  output logic [IDX_W-1:0] ptr_idx,
  output logic             inc_flag
);

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return p + IDX_W'(1);
  endfunction

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      ptr_idx  <= '0;
      inc_flag <= 1'b0;
    end else if (ev_ptr_load) begin
      ptr_idx  <= new_idx;
      inc_flag <= new_inc;
    end else if (ev_step && inc_flag) begin
      ptr_idx  <= ptr_next(ptr_idx);
    end
  end

  AST_PTR_FIXED: assert property (@(posedge sck) disable iff (!rst_n)
    (!ev_ptr_load && !inc_flag) |=> $stable(ptr_idx)); // R5

  AST_PTR_WRAP: assert property (@(posedge sck) disable iff (!rst_n)
    (ev_step && inc_flag && !ev_ptr_load && ptr_idx == LAST_IDX) |=> (ptr_idx == '0)); // R6

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file #(
  parameter int REG_COUNT = 16,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic             rst_n,
  input  logic             sck,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [7:0]       ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [7:0]       rb_data
);

  logic [7:0] regs [REG_COUNT];

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= 8'd0;
    end else if (we) begin
      regs[widx] <= wdata;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  AST_WRITE_LANDS: assert property (@(posedge sck) disable iff (!rst_n)
    we |=> (regs[$past(widx)] == $past(wdata))); // R4

endmodule

// File: rtl/spi_tx_unit.sv
module spi_tx_unit (
  input  logic       rst_n,
  input  logic       csn,
  input  logic       sck,
  input  logic       read_active,
  input  logic [2:0] bit_cnt,
  input  logic [7:0] cur_byte,
  output logic       sdo_bit,
  output logic       sdo_oe
);

  always_ff @(negedge sck or posedge csn or negedge rst_n) begin
    if (!rst_n) begin
      sdo_oe  <= 1'b0;
      sdo_bit <= 1'b0;
    end else if (csn) begin
      sdo_oe  <= 1'b0;
      sdo_bit <= 1'b0;
    end else if (read_active) begin
      sdo_oe  <= 1'b1;
      sdo_bit <= cur_byte[~bit_cnt];
    end
  end

  AST_OE_READ_ONLY: assert property (@(posedge sck) disable iff (!rst_n || csn)
    sdo_oe |-> read_active); // R8

  AST_OE_HOLDS: assert property (@(posedge sck) disable iff (!rst_n || csn)
    sdo_oe |=> sdo_oe); // R8

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_ctl_pkg::*;
#(
  parameter int REG_COUNT = 16,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic             rst_n,
  input  logic             csn,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_byte
);

  frame_st_t        state;
  logic [2:0]       bit_cnt;
  logic [7:0]       rx_byte;
  logic             ev_ptr_load;
  logic             ev_data_wr;
  logic             ev_rd_step;
  logic             read_active;
  logic [IDX_W-1:0] ptr_idx;
  logic             inc_flag;
  logic [7:0]       cur_byte;
  logic             sdo_bit;

  spi_frame_fsm u_fsm (
    .rst_n       (rst_n),
    .csn         (csn),
    .sck         (sck),
    .sdi         (sdi),
    .state       (state),
    .bit_cnt     (bit_cnt),
    .rx_byte     (rx_byte),
    .ev_ptr_load (ev_ptr_load),
    .ev_data_wr  (ev_data_wr),
    .ev_rd_step  (ev_rd_step),
    .read_active (read_active)
  );

  spi_ptr_unit #(.IDX_W(IDX_W)) u_ptr (
    .rst_n       (rst_n),
    .sck         (sck),
    .ev_ptr_load (ev_ptr_load),
    .ev_step     (ev_data_wr || ev_rd_step),
    .new_inc     (rx_byte[7]),
    .new_idx     (rx_byte[IDX_W-1:0]),
    .ptr_idx     (ptr_idx),
    .inc_flag    (inc_flag)
  );

  spi_reg_file #(.REG_COUNT(REG_COUNT)) u_regs (
    .rst_n   (rst_n),
    .sck     (sck),
    .we      (ev_data_wr),
    .widx    (ptr_idx),
    .wdata   (rx_byte),
    .ra_idx  (rd_addr),
    .ra_data (rd_data),
    .rb_idx  (ptr_idx),
    .rb_data (cur_byte)
  );

  spi_tx_unit u_tx (
    .rst_n       (rst_n),
    .csn         (csn),
    .sck         (sck),
    .read_active (read_active),
    .bit_cnt     (bit_cnt),
    .cur_byte    (cur_byte),
    .sdo_bit     (sdo_bit),
    .sdo_oe      (sdo_oe)
  );

  assign sdo     = sdo_oe ? sdo_bit : 1'bz;
  assign wr_stb  = ev_data_wr;
  assign wr_idx  = ptr_idx;
  assign wr_byte = rx_byte;

  AST_STB_NOT_READING: assert property (@(posedge sck) disable iff (!rst_n || csn)
    wr_stb |-> !sdo_oe); // R8

endmodule

// File: tb/tb_spi_reg_port.sv
`timescale 1ns/100ps
module tb_spi_reg_port;

  localparam int NREG = 16;

  logic       rst_n = 1'b0;
  logic       csn   = 1'b1;
  logic       sck   = 1'b0;
  logic       sdi   = 1'b0;
  wire        sdo;
  logic       sdo_oe;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;
  logic       wr_stb;
  logic [3:0] wr_idx;
  logic [7:0] wr_byte;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] exp_regs [NREG];
  int         exp_ptr = 0;
  bit         exp_inc = 1'b0;

  always #2 sck = ~sck;

  spi_reg_port #(.REG_COUNT(NREG)) dut (
    .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 29 + seed * 7 + 3) & 255);
  endfunction

  // One bit onto the wire: set after a falling edge, sampled at the next rising edge.
  task automatic tx_byte(input logic [7:0] b, input int nbits, input bit stb_exp, input int idx_exp);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge sck);
      #0.5 csn = 1'b0;
      sdi = b[i];
      #0.5;
      chk(sdo_oe == 1'b0, "R8 oe low while host sends", int'(sdo_oe), 0);
      if (i == 0) begin
        chk(wr_stb == stb_exp, "R4 strobe on last bit", int'(wr_stb), int'(stb_exp));
        if (stb_exp) begin
          chk(int'(wr_idx) == idx_exp, "R4 strobe index", int'(wr_idx), idx_exp);
          chk(wr_byte == b, "R4 strobe byte", int'(wr_byte), int'(b));
        end
      end else begin
        chk(wr_stb == 1'b0, "R4 no strobe mid byte", int'(wr_stb), 0);
      end
    end
  endtask

  task automatic end_frame();
    @(negedge sck);
    #1 csn = 1'b1;
    #0.5;
    chk(sdo_oe == 1'b0, "R1 oe low after select rises", int'(sdo_oe), 0);
  endtask

  task automatic frame_write(input logic [7:0] pb, input int nbytes, input int seed);
    tx_byte(8'h9E, 8, 1'b0, 0);
    tx_byte(pb, 8, 1'b0, 0);
    exp_inc = pb[7];
    exp_ptr = int'(pb[6:0]) % NREG;
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] d;
      d = pat(k, seed);
      tx_byte(d, 8, 1'b1, exp_ptr);
      exp_regs[exp_ptr] = d;
      if (exp_inc) exp_ptr = (exp_ptr + 1) % NREG;
    end
    end_frame();
  endtask

  task automatic frame_read(input int nbytes, input string tag);
    tx_byte(8'h9F, 8, 1'b0, 0);
    @(posedge sck);
    #0.5 chk(sdo_oe == 1'b0, "R8 oe still low at last header edge", int'(sdo_oe), 0);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
        @(negedge sck);
        #0.5;
        if (k == 0 && i == 7)
          chk(sdo_oe == 1'b1, "R8 oe high at first falling edge", int'(sdo_oe), 1);
        got[i] = sdo;
        @(posedge sck);
        #0.5 chk(sdo_oe && sdo == got[i], "R3 sdo holds across rising edge", int'(sdo), int'(got[i]));
      end
      chk(got == exp_regs[exp_ptr], tag, int'(got), int'(exp_regs[exp_ptr]));
      if (exp_inc) exp_ptr = (exp_ptr + 1) % NREG;
    end
    end_frame();
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NREG; i++) begin
      rd_addr = 4'(i);
      #0.5 chk(rd_data == exp_regs[i], tag, int'(rd_data), int'(exp_regs[i]));
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog timeout act=1 exp=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'd0;
    repeat (5) @(negedge sck);
    rst_n = 1'b1;
    @(negedge sck);
    chk(sdo_oe == 1'b0, "R1 oe low after reset", int'(sdo_oe), 0);
    check_all("R1 R10 registers zero after reset");

    // R1: default pointer 0, step off
    frame_read(2, "R1 default pointer read");

    // R6 R4: auto-step block write crossing the end of the array
    frame_write(8'h85, NREG + 3, 1);
    check_all("R6 R10 block write wraps");

    // R6 R8: partial write setting pointer, then auto-step read across wrap
    frame_write(8'h8C, 0, 0);
    frame_read(NREG + 4, "R6 R8 block read wraps");

    // R5: fixed pointer write and read
    frame_write(8'h03, 3, 2);
    check_all("R5 fixed pointer write");
    frame_read(3, "R5 fixed pointer read");

    // R9: upper index bits fold modulo the array size
    frame_write(8'hB7, 2, 3);
    check_all("R9 index modulo array size");
    frame_write(8'h7A, 1, 4);
    check_all("R9 flag bit seven clear");

    // R7: pointer kept, short data byte discarded
    frame_write(8'h0A, 0, 0);
    tx_byte(8'h9E, 8, 1'b0, 0);
    tx_byte(8'h06, 8, 1'b0, 0);
    exp_inc = 1'b0;
    exp_ptr = 6;
    tx_byte(8'hF5, 5, 1'b0, 0);
    end_frame();
    check_all("R7 short data byte discarded");
    frame_read(1, "R7 pointer from cut frame kept");
    // R7: short pointer byte leaves old pointer
    tx_byte(8'h9E, 8, 1'b0, 0);
    tx_byte(8'h81, 4, 1'b0, 0);
    end_frame();
    frame_read(2, "R7 short pointer byte discarded");

    // R2: every wrong identity, both directions
    for (int d = 0; d < 128; d++) begin
      if (d != 7'b1001111) begin
        tx_byte({7'(d), 1'b0}, 8, 1'b0, 0);
        tx_byte(8'(8'h80 | (d % NREG)), 8, 1'b0, 0);
        tx_byte(8'(~d), 8, 1'b0, 0);
        end_frame();
        tx_byte({7'(d), 1'b1}, 8, 1'b0, 0);
        tx_byte(8'h00, 8, 1'b0, 0);
        end_frame();
      end
    end
    check_all("R2 wrong identity writes nothing");
    frame_read(2, "R2 pointer untouched by wrong identity");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule